// File: doc/BRIEF.md
# Loop Buffering Mode Controller

This controller decides which of three operating modes an issue queue is in. In the idle mode the queue runs as usual. When the decoder reports a loop that fits in the queue, the controller enters the fill mode. In that mode every instruction written into the queue is marked as reusable, and a counter tracks how many have been captured. The fill ends once a whole number of loop bodies is held. That number is the queue depth divided by the loop length, rounded down, so the loop-closing branch has been captured and one more body would not fit. The controller then enters the replay mode. There the fetch and decode front end is gated and branch prediction falls back to a static scheme, while the queue replays its own contents.

Any control-flow deviation during the fill revokes it. A branch misprediction in the fill or replay mode ends it, and a misprediction is how a loop exit normally shows up. On leaving the fill or replay mode, the controller pulses a request that clears every reuse mark. The front-end gate is released in the same cycle as the misprediction, so fetch can restart at once.

Top module: `loop_mode_ctrl`

## Requirements
- R1: After reset, fe_gate, static_pred, mark_en and clear_buf are all 0, and the controller is idle.
- R2: A loop_det pulse in the idle mode with 1 <= loop_len <= DEPTH moves the controller to fill mode on the next clock edge. In fill mode mark_en=1, while fe_gate=0 and static_pred=0.
- R3: A loop_det pulse in the idle mode is ignored when loop_len is 0 or greater than DEPTH, or when mispredict is high in the same cycle.
- R4: The fill ends after exactly floor(DEPTH/loop_len)*loop_len cycles with ent_wr=1. Replay mode starts on the edge that takes the last of those writes. Cycles with ent_wr=0 do not count.
- R5: In replay mode static_pred=1 and mark_en=0. fe_gate=1 while mispredict is low.
- R6: cf_chg=1 in fill mode returns the controller to idle on the next edge. This takes priority over completion of the fill.
- R7: mispredict=1 in fill or replay mode returns the controller to idle on the next edge.
- R8: In replay mode, fe_gate falls in the same cycle that mispredict rises, before any clock edge.
- R9: clear_buf is 1 for exactly the one cycle after an exit from fill or replay mode, and is 0 at all other times.
- R10: loop_det in fill or replay mode has no effect, and cf_chg in replay mode has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| loop_det | input | 1 | Capturable loop detected at decode |
| loop_len | input | $clog2(DEPTH+1) | Static loop body length in entries |
| ent_wr | input | 1 | One instruction written into the queue this cycle |
| cf_chg | input | 1 | Control flow left the loop being captured |
| mispredict | input | 1 | Branch misprediction resolved |
| fe_gate | output | 1 | Gate fetch and decode |
| static_pred | output | 1 | Use static branch prediction |
| mark_en | output | 1 | Set the reuse mark on entries written now |
| clear_buf | output | 1 | Clear all reuse marks |

## Verification
The assertions check on every cycle that the mode outputs stay consistent: gating implies static prediction, marking never overlaps replay, the clear pulse never lasts two cycles, a misprediction always ends replay, and the fill counter stays below its target. Only the bench scenarios show the exact number of writes that ends the fill for each loop length, the handling of lengths out of range, and the priority of deviation over completion. They also show that the gate drops combinationally on a misprediction.

// File: rtl/lbm_pkg.sv
package lbm_pkg;
  typedef enum logic [1:0] {
    MODE_IDLE   = 2'd0,
    MODE_FILL   = 2'd1,
    MODE_REPLAY = 2'd2
  } mode_e;
endpackage

// File: rtl/lbm_fill_tracker.sv
module lbm_fill_tracker #(
  parameter int DEPTH = 16,
  localparam int LW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          active,
  input  logic [LW-1:0] len,
  input  logic          ent_wr,
  output logic          len_ok,
  output logic          fill_done
);
  logic [LW-1:0] count_q, target_q;
  int            iters;

  assign len_ok = (len != '0) && (int'(len) <= DEPTH);

  always_comb begin
    iters = (len != '0) ? (DEPTH / int'(len)) : 0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count_q  <= '0;
      target_q <= '0;
    end else if (start) begin
      count_q  <= '0;
      target_q <= LW'(iters * int'(len));
    end else if (active && ent_wr) begin
      count_q  <= count_q + 1'b1;
    end
  end

  assign fill_done = active && ent_wr && ((count_q + 1'b1) == target_q);

  // R4: the capture count never reaches the target while filling
  assert_fill_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
    active && !$rose(active) |-> count_q < target_q);
endmodule

// File: rtl/lbm_mode_fsm.sv
module lbm_mode_fsm
  import lbm_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  loop_det,
  input  logic  len_ok,
  input  logic  fill_done,
  input  logic  cf_chg,
  input  logic  mispredict,
  output mode_e mode,
  output logic  start,
  output logic  clear_q
);
  mode_e mode_q, mode_d;
  logic  leave;

  always_comb begin
    mode_d = mode_q;
    start  = 1'b0;
    leave  = 1'b0;
    unique case (mode_q)
      MODE_IDLE: if (loop_det && len_ok && !mispredict) begin
        mode_d = MODE_FILL;
        start  = 1'b1;
      end
      MODE_FILL: if (mispredict || cf_chg) begin
        mode_d = MODE_IDLE;
        leave  = 1'b1;
      end else if (fill_done) begin
        mode_d = MODE_REPLAY;
      end
      MODE_REPLAY: if (mispredict) begin
        mode_d = MODE_IDLE;
        leave  = 1'b1;
      end
      default: mode_d = MODE_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q  <= MODE_IDLE;
      clear_q <= 1'b0;
    end else begin
      mode_q  <= mode_d;
      clear_q <= leave;
    end
  end

  assign mode = mode_q;

  // R7: a misprediction in replay always returns to idle
  assert_replay_exit_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MODE_REPLAY) && mispredict |=> mode_q == MODE_IDLE);
  // R6: deviation during the fill revokes it
  assert_fill_revoke_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MODE_FILL) && cf_chg |=> mode_q == MODE_IDLE);
endmodule

// File: rtl/loop_mode_ctrl.sv
module loop_mode_ctrl
  import lbm_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int LW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          loop_det,
  input  logic [LW-1:0] loop_len,
  input  logic          ent_wr,
  input  logic          cf_chg,
  input  logic          mispredict,
  output logic          fe_gate,
  output logic          static_pred,
  output logic          mark_en,
  output logic          clear_buf
);
  mode_e mode;
  logic  start, len_ok, fill_done, clear_q;

  lbm_fill_tracker #(.DEPTH(DEPTH)) u_track (
    .clk(clk), .rst_n(rst_n), .start(start),
    .active(mode == MODE_FILL), .len(loop_len), .ent_wr(ent_wr),
    .len_ok(len_ok), .fill_done(fill_done)
  );

  lbm_mode_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .loop_det(loop_det), .len_ok(len_ok),
    .fill_done(fill_done), .cf_chg(cf_chg), .mispredict(mispredict),
    .mode(mode), .start(start), .clear_q(clear_q)
  );

  assign static_pred = (mode == MODE_REPLAY);
  assign fe_gate     = (mode == MODE_REPLAY) && !mispredict;
  assign mark_en     = (mode == MODE_FILL);
  assign clear_buf   = clear_q;

  // R5: gating happens only under static prediction
  assert_gate_static_R5: assert property (@(posedge clk) disable iff (!rst_n)
    fe_gate |-> static_pred);
  // R5: marking and replay never overlap
  assert_mark_excl_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(mark_en && static_pred));
  // R9: the clear request is a single-cycle pulse
  assert_clear_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    clear_buf |=> !clear_buf);
  // R9: clear follows only a stay in fill or replay
  assert_clear_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(clear_buf) |-> $past(mark_en || static_pred));
endmodule

// File: tb/tb_loop_mode_ctrl.sv
module tb_loop_mode_ctrl;
  localparam int DEPTH = 16;
  localparam int LW = $clog2(DEPTH + 1);

  logic clk = 0, rst_n = 0;
  logic loop_det = 0, ent_wr = 0, cf_chg = 0, mispredict = 0;
  logic [LW-1:0] loop_len = '0;
  logic fe_gate, static_pred, mark_en, clear_buf;
  int total = 0, bad = 0;

  always #10 clk = ~clk;

  loop_mode_ctrl #(.DEPTH(DEPTH)) dut (
    .clk(clk), .rst_n(rst_n), .loop_det(loop_det), .loop_len(loop_len),
    .ent_wr(ent_wr), .cf_chg(cf_chg), .mispredict(mispredict),
    .fe_gate(fe_gate), .static_pred(static_pred), .mark_en(mark_en),
    .clear_buf(clear_buf)
  );

  task automatic chk(string req, logic [3:0] exp);
    logic [3:0] act;
    act = {fe_gate, static_pred, mark_en, clear_buf};
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s gate/static/mark/clear act=%b exp=%b", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
    loop_det = 0; ent_wr = 0; cf_chg = 0; mispredict = 0;
  endtask

  task automatic enter_fill(int len);
    loop_det = 1; loop_len = LW'(len); tick();
  endtask

  initial begin
    #(20 * 200000);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1; chk("R1", 4'b0000);
    rst_n = 1; tick(); chk("R1", 4'b0000);

    // sweep all loop lengths including out of range
    for (int len = 0; len <= DEPTH + 1; len++) begin
      int tgt;
      enter_fill(len);
      if (len == 0 || len > DEPTH) begin
        chk("R3", 4'b0000);
        continue;
      end
      chk("R2", 4'b0010);
      tgt = (DEPTH / len) * len;
      for (int i = 0; i < tgt - 1; i++) begin
        ent_wr = 1;
        if (i == 0) loop_det = 1; // R10 detect ignored in fill
        tick();
        chk("R4", 4'b0010);
        if (i % 3 == 0) begin tick(); chk("R4", 4'b0010); end
      end
      ent_wr = 1; tick();
      chk("R4", 4'b1100);
      loop_det = 1; cf_chg = 1; tick(); chk("R10", 4'b1100);
      chk("R5", 4'b1100);
      mispredict = 1; #1; chk("R8", 4'b0100);
      tick(); chk("R9", 4'b0001);
      tick(); chk("R9", 4'b0000);
    end

    // deviation revokes fill, even on the completing write
    enter_fill(4); chk("R2", 4'b0010);
    for (int i = 0; i < 15; i++) begin ent_wr = 1; tick(); end
    ent_wr = 1; cf_chg = 1; tick(); chk("R6", 4'b0001);
    tick(); chk("R9", 4'b0000);

    // misprediction during fill
    enter_fill(5); ent_wr = 1; tick();
    mispredict = 1; tick(); chk("R7", 4'b0001);
    tick(); chk("R7", 4'b0000);

    // misprediction wins over detect in idle
    loop_det = 1; loop_len = LW'(3); mispredict = 1; tick();
    chk("R3", 4'b0000);
    tick(); chk("R3", 4'b0000);

    // a fresh fill after revoke restarts the count
    enter_fill(7);
    for (int i = 0; i < 3; i++) begin ent_wr = 1; tick(); end
    cf_chg = 1; tick(); tick();
    enter_fill(7);
    for (int i = 0; i < 13; i++) begin ent_wr = 1; tick(); end
    chk("R4", 4'b0010);
    ent_wr = 1; tick(); chk("R4", 4'b1100);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule